// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and passes them to a processor through one interrupt output. Each line has its own mask bit. A fixed priority ranks the lines, with line 0 the most urgent. An in-service register records which requests the processor is currently handling. The block raises its interrupt output only when an unmasked request outranks every request already in service.

The processor answers the interrupt with an acknowledge pulse. One cycle later the block drives an 8-bit vector, valid for one cycle. The vector holds a programmable 5-bit base in its upper bits and the 3-bit index of the winning line in its lower bits. In the same step the block marks the winning line as in service. When the handler finishes, the processor pulses end-of-interrupt. This clears the most urgent in-service entry, so nested handlers unwind in the right order.

A small write port loads the mask and the vector base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out`, `vec_valid` and `vec_out` are 0, the in-service register is empty, and all mask bits are 1, so no request line can raise `irq_out` until the mask is written.
- R2: A line whose mask bit is 1 never causes `irq_out`. A line whose mask bit is 0 causes `irq_out` within three cycles if nothing of equal or higher priority is in service.
- R3: When several unmasked lines request at once, the lowest-numbered line wins, and its index appears in `vec_out[2:0]`.
- R4: The write port is selected by `cfg_sel`. With `cfg_sel`=0, a write loads `cfg_wdata` into the mask, where bit i masks line i. With `cfg_sel`=1, a write loads `cfg_wdata[4:0]` as the vector base. The vector delivered is {base, index}.
- R5: `vec_valid` is high for exactly one cycle, namely the cycle after an accepted acknowledge. `vec_out` is 0 whenever `vec_valid` is low.
- R6: An acknowledge taken while `irq_out` is high drops `irq_out` in the next cycle.
- R7: While a line is in service, requests of equal or lower priority do not raise `irq_out`. An unmasked request of higher priority raises it again, which allows nesting.
- R8: An end-of-interrupt pulse clears only the most urgent set in-service bit. Less urgent in-service entries keep blocking.
- R9: An acknowledge while `irq_out` is low has no effect: no vector appears and the in-service register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 1 | 0 selects the mask, 1 selects the vector base |
| cfg_wdata | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, high for one cycle after an accepted acknowledge |
| vec_out | output | 8 | Vector number, 0 when not valid |

## Verification
The assertions assume that `ack` and `eoi` are single-cycle pulses from a processor that is otherwise idle. They also assume that `eoi` is issued only while at least one entry is in service, and that request lines stay stable while an acknowledge is outstanding. The stimulus follows these rules. It changes lines, mask and base only while no acknowledge is pending. It waits a few cycles after each change before sampling. It issues one end-of-interrupt for every acknowledge it takes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int VEC_W     = 8;
    localparam int BASE_W    = VEC_W - IDX_W;

    typedef struct packed {
        logic                 irq;
        logic                 vec_valid;
        logic [VEC_W-1:0]     vec;
        logic [NUM_LINES-1:0] req;
    } irqc_state_t;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
    parameter int N      = 8,
    parameter int BASE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N-1:0]      mask_o,
    output logic [BASE_W-1:0] base_o
);
    logic [N-1:0]      mask_d, mask_q;
    logic [BASE_W-1:0] base_d, base_q;

    always_comb begin
        mask_d = mask_q;
        base_d = base_q;
        if (we_i) begin
            if (sel_i) base_d = wdata_i[BASE_W-1:0];
            else       mask_d = wdata_i[N-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            base_q <= '0;
        end else begin
            mask_q <= mask_d;
            base_q <= base_d;
        end
    end

    assign mask_o = mask_q;
    assign base_o = base_q;
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [IDX_W-1:0] set_idx_i,
    input  logic             clr_i,
    output logic [N-1:0]     isr_o
);
    logic [N-1:0] isr_d, isr_q;
    logic [N-1:0] keep_mask;
    logic [N-1:0] set_mask;

    always_comb begin
        // x & (x-1) drops the lowest set bit, which is the most urgent entry
        keep_mask = clr_i ? (isr_q - N'(1)) : '1;
        set_mask  = set_i ? (N'(1) << set_idx_i) : '0;
        isr_d     = (isr_q & keep_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr_o = isr_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       irq_lines,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_out,
    output logic             vec_valid,
    output logic [7:0]       vec_out
);
    irqc_state_t st_d, st_q;

    logic [NUM_LINES-1:0] mask_q;
    logic [BASE_W-1:0]    base_q;
    logic [NUM_LINES-1:0] isr_q;
    logic [NUM_LINES-1:0] pend;
    logic                 p_found, s_found;
    logic [IDX_W-1:0]     p_idx, s_idx;
    logic                 outrank;
    logic                 take;

    irqc_cfg_regs #(.N(NUM_LINES), .BASE_W(BASE_W), .DATA_W(VEC_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .mask_o  (mask_q),
        .base_o  (base_q)
    );

    irqc_inservice #(.N(NUM_LINES)) u_isr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take),
        .set_idx_i (p_idx),
        .clr_i     (eoi),
        .isr_o     (isr_q)
    );

    assign pend = st_q.req & ~mask_q;

    irqc_prio_enc #(.N(NUM_LINES)) u_pend_enc (
        .bits_i  (pend),
        .found_o (p_found),
        .idx_o   (p_idx)
    );

    irqc_prio_enc #(.N(NUM_LINES)) u_svc_enc (
        .bits_i  (isr_q),
        .found_o (s_found),
        .idx_o   (s_idx)
    );

    always_comb begin
        outrank = p_found && (!s_found || (p_idx < s_idx));
        take    = ack && st_q.irq && p_found;

        st_d           = st_q;
        st_d.irq       = outrank && !take;
        st_d.vec_valid = take;
        st_d.vec       = take ? {base_q, p_idx} : '0;
        st_d.req       = irq_lines & ~(take ? (NUM_LINES'(1) << p_idx) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out   = st_q.irq;
    assign vec_valid = st_q.vec_valid;
    assign vec_out   = st_q.vec;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_out,
    input logic       ack,
    input logic       vec_valid,
    input logic [7:0] vec_out,
    input logic [7:0] isr_q
);
    p_vec_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == 8'h00));

    p_vec_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);

    p_vec_follows_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> vec_valid);

    p_no_vec_without_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && ack) |=> !vec_valid);

    p_vec_in_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> isr_q[vec_out[2:0]]);
endmodule

bind prio_irq_ctrl irqc_checker u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .ack       (ack),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .isr_q     (isr_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack(ack), .eoi(eoi),
        .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    function automatic logic [2:0] lowest_idx(input logic [7:0] v);
        logic [2:0] r = '0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1;
        tick(1);
        eoi = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 irq_out", {7'd0, irq_out}, 8'h00);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        check("R1 vec_out", vec_out, 8'h00);
        irq_lines = 8'hFF;
        tick(3);
        check("R1 all masked after reset", {7'd0, irq_out}, 8'h00);

        // R2/R4: mask line 2, base 0x13
        irq_lines = 8'h00;
        cfg_write(1'b0, 8'b0000_0100);
        cfg_write(1'b1, 8'h13);
        irq_lines = 8'b0010_0100;
        tick(3);
        check("R2 unmasked line raises irq", {7'd0, irq_out}, 8'h01);
        pulse_ack();
        check("R4 vector base|5 with line 2 masked", vec_out, 8'h9D);
        check("R6 irq drops after ack", {7'd0, irq_out}, 8'h00);
        tick(1);
        check("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
        check("R5 vec_out zero when idle", vec_out, 8'h00);

        // R7: line 5 in service blocks equal and lower
        tick(2);
        check("R7 equal priority blocked", {7'd0, irq_out}, 8'h00);
        irq_lines = 8'b1010_0100;
        tick(3);
        check("R7 lower priority blocked", {7'd0, irq_out}, 8'h00);
        cfg_write(1'b0, 8'h00);
        tick(3);
        check("R7 higher priority nests", {7'd0, irq_out}, 8'h01);
        pulse_ack();
        check("R3 nested vector line 2", vec_out, 8'h9A);

        // R9: ack while irq low
        tick(3);
        pulse_ack();
        check("R9 stray ack gives no vector", {7'd0, vec_valid}, 8'h00);
        check("R9 stray ack gives zero vec_out", vec_out, 8'h00);

        // R8: only line 7 requested, isr holds {2,5}
        irq_lines = 8'b1000_0000;
        tick(3);
        check("R8 line 7 blocked before eoi", {7'd0, irq_out}, 8'h00);
        pulse_eoi();
        tick(3);
        check("R8 eoi cleared only line 2", {7'd0, irq_out}, 8'h00);
        pulse_eoi();
        tick(3);
        check("R8 second eoi clears line 5", {7'd0, irq_out}, 8'h01);
        pulse_ack();
        check("R8 vector line 7", vec_out, 8'h9F);
        irq_lines = 8'h00;
        pulse_eoi();
        tick(2);

        // R3: several lines at once
        irq_lines = 8'b0101_1000;
        tick(3);
        pulse_ack();
        check("R3 lowest of 3,4,6 wins", vec_out, 8'h9B);
        irq_lines = 8'h00;
        pulse_eoi();
        tick(2);

        // Random phase: R2, R3, R4
        void'($urandom(32'h1234_5678));
        for (int it = 0; it < 300; it++) begin
            logic [7:0] m, l, b;
            logic       exp_irq;
            m = 8'($urandom);
            l = 8'($urandom);
            b = 8'($urandom);
            if (it % 7 == 0) m = 8'hFF;
            if (it % 5 == 0) l = 8'h80;
            cfg_write(1'b0, m);
            cfg_write(1'b1, b);
            irq_lines = l;
            tick(3);
            exp_irq = |(l & ~m);
            check("R2 random irq_out", {7'd0, irq_out}, {7'd0, exp_irq});
            if (exp_irq) begin
                pulse_ack();
                check("R4 random vector", vec_out, {b[4:0], lowest_idx(l & ~m)});
                irq_lines = 8'h00;
                pulse_eoi();
            end else begin
                irq_lines = 8'h00;
            end
            tick(2);
        end

        finish_run();
    end
endmodule